// File: doc/BRIEF.md
# Two-Way Handshake Mailbox

This block moves one data word at a time from a producer to a consumer when neither side's pace is known in advance. Two one-bit hardware semaphores carry the coordination. The first semaphore tells the consumer that a word is present. The second tells the producer that the word has been taken. The producer therefore stays blocked after each post until the consumer has acknowledged. This keeps the transfer correct whichever side is slower, and no word is overwritten or read twice.

Both semaphores start out taken: the first belongs to the producer and the second to the consumer. The producer offers a word on a valid/ready pair. A post is accepted only in a cycle where `put_ready` is high. The producer is expected to hold off until then, so `put_ready` is its back-pressure. The consumer sees `get_valid` and `get_data`, and it completes the transfer with a one-cycle `get_ack`. A strobe sent out of turn is dropped, and it sets an error flag for that side. The flag stays set until reset. Each side can either poll its ready/valid status or stall on it.

Top module: `mbx_handshake`

## Requirements
- R1: While `rst` is high and after it is released, `put_ready` is 1, `get_valid` is 0, `put_err` and `get_err` are 0, and `get_data` is all zeros.
- R2: A post is a cycle with `put_valid` and `put_ready` both high. It loads `put_data` into the mailbox. In the next cycle `get_valid` is 1, `put_ready` is 0 and `get_data` equals the posted word.
- R3: While `get_valid` is 1, `get_data` stays unchanged and equals the most recently accepted post.
- R4: An acknowledge is a cycle with `get_ack` and `get_valid` both high. In the next cycle `get_valid` is 0 and `put_ready` is still 0. In the cycle after that, `put_ready` returns to 1.
- R5: From an accepted post until the acknowledge completes as in R4, `put_ready` stays 0, however long the consumer waits.
- R6: A `put_valid` in a cycle where `put_ready` is 0 is ignored: `get_data` and `get_valid` are unchanged. It sets `put_err` to 1 in the next cycle.
- R7: A `get_ack` in a cycle where `get_valid` is 0 is ignored: `put_ready` and `get_valid` are unchanged. It sets `get_err` to 1 in the next cycle.
- R8: Once set, `put_err` and `get_err` stay 1 until `rst` is asserted.
- R9: `put_ready` and `get_valid` are never 1 in the same cycle.
- R10: For any mix of producer and consumer delays, every accepted word is delivered exactly once and in posting order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| put_valid | input | 1 | Producer post strobe |
| put_data | input | DATA_W | Word offered by the producer |
| put_ready | output | 1 | Producer may post (high) or is blocked (low) |
| get_valid | output | 1 | A word is waiting for the consumer |
| get_data | output | DATA_W | Word held in the mailbox |
| get_ack | input | 1 | Consumer acknowledge strobe |
| put_err | output | 1 | Sticky flag: a post was attempted while blocked |
| get_err | output | 1 | Sticky flag: an acknowledge was attempted while empty |

## Verification
The main transfer is swept over every pairing of producer delay and consumer delay from zero to three cycles, four words per pairing, with each word's value computed from its indices. This covers a faster sender, a faster receiver, equal pacing, and back-to-back strobes. Each pattern shows whether the sender really waits for the acknowledge and whether words are lost, duplicated or reordered. A directed single transfer pins the cycle-exact latencies on both sides. Separate runs with out-of-turn strobes on each side confirm that the data and status stay untouched and that only the matching error flag rises and stays set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    SND_OPEN = 1'b0,
    SND_HOLD = 1'b1
  } snd_phase_e;
endpackage

// File: rtl/mbx_semaphore.sv
module mbx_semaphore #(
  parameter bit INIT_FREE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic give_i,
  input  logic take_i,
  output logic free_o
);
  logic free_q;

  always_ff @(posedge clk) begin
    if (rst)                  free_q <= INIT_FREE;
    else if (take_i && free_q) free_q <= 1'b0;
    else if (give_i)          free_q <= 1'b1;
  end

  assign free_o = free_q;

  // R10: a release never hits a semaphore that is already free
  assert_single_release_R10: assert property (@(posedge clk) disable iff (rst)
    give_i |-> !free_q);
endmodule

// File: rtl/mbx_send_ctl.sv
module mbx_send_ctl
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic put_valid,
  input  logic s2_free,
  output logic put_ready,
  output logic post_fire,
  output logic s2_take,
  output logic put_err
);
  snd_phase_e phase_q;
  logic       err_q;

  assign put_ready = (phase_q == SND_OPEN);
  assign post_fire = put_valid && put_ready;
  assign s2_take   = (phase_q == SND_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= SND_OPEN;
    end else begin
      case (phase_q)
        SND_OPEN: if (post_fire) phase_q <= SND_HOLD;
        SND_HOLD: if (s2_free)   phase_q <= SND_OPEN;
        default:                 phase_q <= SND_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         err_q <= 1'b0;
    else if (put_valid && !put_ready) err_q <= 1'b1;
  end

  assign put_err = err_q;

  assert_put_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    put_err |=> put_err);
  assert_blocked_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (!put_ready && !s2_free) |=> !put_ready);
endmodule

// File: rtl/mbx_recv_ctl.sv
module mbx_recv_ctl (
  input  logic clk,
  input  logic rst,
  input  logic get_ack,
  input  logic s1_free,
  output logic get_valid,
  output logic ack_fire,
  output logic get_err
);
  logic err_q;

  assign get_valid = s1_free;
  assign ack_fire  = get_ack && s1_free;

  always_ff @(posedge clk) begin
    if (rst)                      err_q <= 1'b0;
    else if (get_ack && !s1_free) err_q <= 1'b1;
  end

  assign get_err = err_q;

  assert_get_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    get_err |=> get_err);
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put_valid,
  input  logic [DATA_W-1:0] put_data,
  output logic              put_ready,
  output logic              get_valid,
  output logic [DATA_W-1:0] get_data,
  input  logic              get_ack,
  output logic              put_err,
  output logic              get_err
);
  localparam logic [DATA_W-1:0] DATA_CLEAR = '0;

  logic s1_free, s2_free;
  logic post_fire, s2_take, ack_fire;
  logic [DATA_W-1:0] data_q;

  // S1: released by the producer's post, taken by the consumer's acknowledge
  mbx_semaphore #(.INIT_FREE(1'b0)) u_sem_full (
    .clk(clk), .rst(rst), .give_i(post_fire), .take_i(ack_fire), .free_o(s1_free)
  );

  // S2: released by the consumer's acknowledge, taken by the waiting producer
  mbx_semaphore #(.INIT_FREE(1'b0)) u_sem_done (
    .clk(clk), .rst(rst), .give_i(ack_fire), .take_i(s2_take), .free_o(s2_free)
  );

  mbx_send_ctl u_send (
    .clk(clk), .rst(rst), .put_valid(put_valid), .s2_free(s2_free),
    .put_ready(put_ready), .post_fire(post_fire), .s2_take(s2_take), .put_err(put_err)
  );

  mbx_recv_ctl u_recv (
    .clk(clk), .rst(rst), .get_ack(get_ack), .s1_free(s1_free),
    .get_valid(get_valid), .ack_fire(ack_fire), .get_err(get_err)
  );

  always_ff @(posedge clk) begin
    if (rst)            data_q <= DATA_CLEAR;
    else if (post_fire) data_q <= put_data;
  end

  assign get_data = data_q;

  assert_ready_valid_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(put_ready && get_valid));
  assert_post_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (put_valid && put_ready) |=> (get_valid && !put_ready && get_data == $past(put_data)));
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (get_valid && !get_ack) |=> (get_valid && $stable(get_data)));
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (rst)
    (get_ack && get_valid) |=> (!get_valid && !put_ready) ##1 put_ready);
  assert_stray_post_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (put_valid && !put_ready && !get_ack) |=> ($stable(get_data) && put_err));
endmodule

// File: tb/mbx_handshake_tb.sv
module mbx_handshake_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic put_valid = 1'b0;
  logic [W-1:0] put_data = '0;
  logic put_ready, get_valid, get_ack, put_err, get_err;
  logic [W-1:0] get_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  initial get_ack = 1'b0;
  always #4 clk = ~clk;

  mbx_handshake #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .put_valid(put_valid), .put_data(put_data),
    .put_ready(put_ready), .get_valid(get_valid), .get_data(get_data),
    .get_ack(get_ack), .put_err(put_err), .get_err(get_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] word_of(int pd, int cd, int i);
    return W'((pd * 16 + cd * 4 + i) * 37 + 11);
  endfunction

  // R9 monitor
  always @(negedge clk)
    if (!rst && !done) check("R9", {31'b0, put_ready && get_valid}, 32'd0);

  task automatic do_reset();
    rst = 1'b1;
    put_valid = 1'b0;
    get_ack = 1'b0;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  initial begin
    do_reset();
    check("R1 put_ready", put_ready, 1);
    check("R1 get_valid", get_valid, 0);
    check("R1 put_err", put_err, 0);
    check("R1 get_err", get_err, 0);
    check("R1 get_data", get_data, 0);

    put_valid = 1'b1; put_data = 8'hA5; step(); put_valid = 1'b0;
    check("R2 get_valid", get_valid, 1);
    check("R2 put_ready", put_ready, 0);
    check("R2 get_data", get_data, 8'hA5);

    put_valid = 1'b1; put_data = 8'h5A; step(); put_valid = 1'b0;
    check("R6 put_err", put_err, 1);
    check("R6 get_data", get_data, 8'hA5);
    check("R6 get_valid", get_valid, 1);
    check("R6 get_err", get_err, 0);

    step(); step(); step();
    check("R3 get_data", get_data, 8'hA5);
    check("R5 put_ready", put_ready, 0);

    get_ack = 1'b1; step(); get_ack = 1'b0;
    check("R4 get_valid", get_valid, 0);
    check("R4 put_ready early", put_ready, 0);
    step();
    check("R4 put_ready", put_ready, 1);

    get_ack = 1'b1; step(); get_ack = 1'b0;
    check("R7 get_err", get_err, 1);
    check("R7 put_ready", put_ready, 1);
    check("R7 get_valid", get_valid, 0);

    step(); step(); step();
    check("R8 put_err", put_err, 1);
    check("R8 get_err", get_err, 1);
    do_reset();
    check("R8 put_err cleared", put_err, 0);
    check("R8 get_err cleared", get_err, 0);

    for (int pd = 0; pd < 4; pd++) begin
      for (int cd = 0; cd < 4; cd++) begin
        fork
          begin
            for (int i = 0; i < 4; i++) begin
              repeat (pd) step();
              while (!put_ready) step();
              put_valid = 1'b1;
              put_data = word_of(pd, cd, i);
              step();
              put_valid = 1'b0;
            end
          end
          begin
            for (int i = 0; i < 4; i++) begin
              while (!get_valid) step();
              repeat (cd) step();
              check("R10 word", get_data, word_of(pd, cd, i));
              check("R5 sender blocked", put_ready, 0);
              get_ack = 1'b1;
              step();
              get_ack = 1'b0;
            end
          end
        join
        step(); step();
        check("R10 drained", get_valid, 0);
        check("R10 no error", {30'b0, put_err, get_err}, 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule